// File: doc/BRIEF.md
# Two-Group Interrupt Controller

This block gathers interrupt requests from on-chip peripherals and from external pins, and reduces them to two request lines for the CPU. One line is non-maskable and one is maskable. The non-maskable group holds two sources: external input 0 and the auto-mute event. The maskable group is split into three subgroups. Two of them carry the six events of one serial-bus channel each. The third carries ADC-done, vsync, external input 1 and base-timer wrap.

Every source sets its own pending flag, and each flag has an enable bit beside it. Software uses a small synchronous register port to read the flags, clear them by writing 1, program the enables, choose the trigger edge of each external input and read a per-subgroup summary. The two external inputs and vsync pass through a two-flop synchronizer before edge detection. The other sources are single-cycle strobes in the clock domain.

Register map (4-bit address, 8-bit data, unmapped addresses read 0):

| Address | Register | Bit layout |
|---|---|---|
| 0 | NMI flags | bit0 external input 0, bit1 mute |
| 1 | NMI enables | same layout as address 0 |
| 2 | Bus-channel-0 flags | bit0 SCL low, bit1 address match, bit2 transmit done, bit3 receive done, bit4 no-ack, bit5 stop |
| 3 | Bus-channel-0 enables | same layout as address 2 |
| 4 | Bus-channel-1 flags | same layout as address 2 |
| 5 | Bus-channel-1 enables | same layout as address 2 |
| 6 | Misc flags | bit0 ADC done, bit1 vsync, bit2 external input 1, bit3 timer wrap |
| 7 | Misc enables | same layout as address 6 |
| 8 | Edge select | bit0 external input 0, bit1 external input 1 (0 = rising, 1 = falling) |
| 9 | Status, read-only | bit g set while subgroup g has an enabled pending source |

Top module: `irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, and nmi_o and irq_o are low.
- R2: A source event sets its pending flag whether or not the source is enabled. The enable bit only decides whether the flag drives a request line.
- R3: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. When an event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R4: irq_o is high exactly while some maskable flag is pending and enabled. It falls as soon as that flag is cleared or its enable is removed.
- R5: nmi_o is high for one cycle after each cycle in which an enabled NMI-group event occurs. An NMI-group event whose enable is 0 sets its flag but gives no pulse.
- R6: External inputs 0 and 1 trigger on the edge chosen by their edge-select bit (0 = rising, 1 = falling). The opposite edge sets no flag.
- R7: The vsync flag is set on each rising edge of vsync_i and never on a falling edge.
- R8: Each source sets only its own flag, at the group and bit position given in the register map. Events on one bus channel leave the other channel's flags untouched.
- R9: Status bit g (address 9) reads 1 exactly while maskable subgroup g has a pending, enabled source. Bus channel 0 is subgroup 0, bus channel 1 is subgroup 1, and the misc group is subgroup 2.
- R10: The timer-wrap, ADC-done, mute and bus-event inputs are single-cycle strobes. A strobe shows in its flag at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext0_i | input | 1 | External interrupt pin 0 (asynchronous) |
| ext1_i | input | 1 | External interrupt pin 1 (asynchronous) |
| vsync_i | input | 1 | Vertical sync input (asynchronous) |
| mute_evt_i | input | 1 | Auto-mute event strobe |
| adc_done_i | input | 1 | ADC conversion-done strobe |
| tmr_wrap_i | input | 1 | Base-timer FFh-to-00h wrap strobe |
| bus0_evt_i | input | 6 | Serial-bus channel 0 event strobes |
| bus1_evt_i | input | 6 | Serial-bus channel 1 event strobes |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| nmi_o | output | 1 | Non-maskable request pulse |
| irq_o | output | 1 | Maskable request level |

## Verification
The flag and request logic is driven with isolated strobes, a strobe that lands together with a clearing write, and multi-bit bus patterns such as 2Ah and 15h. Together these separate correct bit placement and channel isolation from crossed or shared flags. The external pins are toggled in both directions under both edge-select settings, which shows whether the edge choice is honoured or ignored. The NMI line is driven by events with the enable on and off, and the bench counts the cycles nmi_o is high, so a level output or an ungated pulse is caught. The maskable line is watched while enables and flags are removed in turn, which shows whether irq_o follows the enable as well as the flag.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DW       = 8;
  localparam int AW       = 4;
  localparam int NMI_W    = 2;
  localparam int BUS_W    = 6;
  localparam int MISC_W   = 4;
  localparam int N_PINS   = 3;
  localparam int N_SUBGRP = 3;

  localparam logic [AW-1:0] A_NMI_FLAG = 4'h0;
  localparam logic [AW-1:0] A_NMI_EN   = 4'h1;
  localparam logic [AW-1:0] A_B0_FLAG  = 4'h2;
  localparam logic [AW-1:0] A_B0_EN    = 4'h3;
  localparam logic [AW-1:0] A_B1_FLAG  = 4'h4;
  localparam logic [AW-1:0] A_B1_EN    = 4'h5;
  localparam logic [AW-1:0] A_MS_FLAG  = 4'h6;
  localparam logic [AW-1:0] A_MS_EN    = 4'h7;
  localparam logic [AW-1:0] A_EDGE     = 4'h8;
  localparam logic [AW-1:0] A_STATUS   = 4'h9;

  // pin index into the synchronizer array
  localparam int PIN_EXT0  = 0;
  localparam int PIN_EXT1  = 1;
  localparam int PIN_VSYNC = 2;

  // misc group bit positions
  localparam int MS_ADC = 0;
  localparam int MS_VS  = 1;
  localparam int MS_E1  = 2;
  localparam int MS_TMR = 3;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic evt_o
);
  // STAGES synchronizer flops plus one for the previous synced value
  logic [STAGES:0] chain_q, chain_d;
  logic cur, prev;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign cur   = chain_q[STAGES-1];
  assign prev  = chain_q[STAGES];
  assign evt_o = fall_sel_i ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/irq_group.sv
module irq_group #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] en_o,
  output logic         active_o
);
  logic [W-1:0] flag_q, flag_d, en_q, en_d;
  logic [W-1:0] clr_mask;

  always_comb begin
    clr_mask = clr_we_i ? wdata_i : '0;
    // set dominates clear
    flag_d   = (flag_q & ~clr_mask) | evt_i;
    en_d     = en_we_i ? wdata_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (en_we_i) en_q <= en_d;
    end
  end

  assign flag_o   = flag_q;
  assign en_o     = en_q;
  assign active_o = |(flag_q & en_q);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext0_i,
  input  logic              ext1_i,
  input  logic              vsync_i,
  input  logic              mute_evt_i,
  input  logic              adc_done_i,
  input  logic              tmr_wrap_i,
  input  logic [BUS_W-1:0]  bus0_evt_i,
  input  logic [BUS_W-1:0]  bus1_evt_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              nmi_o,
  output logic              irq_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // edge-select register
  logic [1:0] edge_q, edge_d;
  logic       edge_we;
  assign edge_we = reg_we_i && (reg_addr_i == A_EDGE);
  always_comb edge_d = edge_we ? reg_wdata_i[1:0] : edge_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     edge_q <= '0;
    else if (edge_we) edge_q <= edge_d;
  end

  // pin synchronizers and edge detectors
  logic [N_PINS-1:0] pin_raw, pin_fall, pin_evt;
  assign pin_raw  = {vsync_i, ext1_i, ext0_i};
  assign pin_fall = {1'b0, edge_q[1], edge_q[0]};

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    irq_sync_edge #(.STAGES(SYNC_STAGES)) u_se (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .pin_i      (pin_raw[p]),
      .fall_sel_i (pin_fall[p]),
      .evt_o      (pin_evt[p])
    );
  end

  // group event vectors
  logic [NMI_W-1:0]  evt_nmi;
  logic [MISC_W-1:0] evt_ms;
  assign evt_nmi = {mute_evt_i, pin_evt[PIN_EXT0]};
  always_comb begin
    evt_ms         = '0;
    evt_ms[MS_ADC] = adc_done_i;
    evt_ms[MS_VS]  = pin_evt[PIN_VSYNC];
    evt_ms[MS_E1]  = pin_evt[PIN_EXT1];
    evt_ms[MS_TMR] = tmr_wrap_i;
  end

  logic [NMI_W-1:0]  flag_nmi, en_nmi;
  logic [BUS_W-1:0]  flag_b0, en_b0, flag_b1, en_b1;
  logic [MISC_W-1:0] flag_ms, en_ms;
  logic              act_nmi;
  logic [N_SUBGRP-1:0] sub_act;

  irq_group #(.W(NMI_W)) u_nmi (
    .clk(clk), .rst_n(rst_n_s), .evt_i(evt_nmi),
    .clr_we_i(reg_we_i && reg_addr_i == A_NMI_FLAG),
    .en_we_i (reg_we_i && reg_addr_i == A_NMI_EN),
    .wdata_i (reg_wdata_i[NMI_W-1:0]),
    .flag_o(flag_nmi), .en_o(en_nmi), .active_o(act_nmi)
  );

  irq_group #(.W(BUS_W)) u_bus0 (
    .clk(clk), .rst_n(rst_n_s), .evt_i(bus0_evt_i),
    .clr_we_i(reg_we_i && reg_addr_i == A_B0_FLAG),
    .en_we_i (reg_we_i && reg_addr_i == A_B0_EN),
    .wdata_i (reg_wdata_i[BUS_W-1:0]),
    .flag_o(flag_b0), .en_o(en_b0), .active_o(sub_act[0])
  );

  irq_group #(.W(BUS_W)) u_bus1 (
    .clk(clk), .rst_n(rst_n_s), .evt_i(bus1_evt_i),
    .clr_we_i(reg_we_i && reg_addr_i == A_B1_FLAG),
    .en_we_i (reg_we_i && reg_addr_i == A_B1_EN),
    .wdata_i (reg_wdata_i[BUS_W-1:0]),
    .flag_o(flag_b1), .en_o(en_b1), .active_o(sub_act[1])
  );

  irq_group #(.W(MISC_W)) u_misc (
    .clk(clk), .rst_n(rst_n_s), .evt_i(evt_ms),
    .clr_we_i(reg_we_i && reg_addr_i == A_MS_FLAG),
    .en_we_i (reg_we_i && reg_addr_i == A_MS_EN),
    .wdata_i (reg_wdata_i[MISC_W-1:0]),
    .flag_o(flag_ms), .en_o(en_ms), .active_o(sub_act[2])
  );

  // NMI: one-cycle pulse per cycle carrying an enabled event
  logic nmi_q, nmi_d;
  always_comb nmi_d = |(evt_nmi & en_nmi);
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) nmi_q <= 1'b0;
    else          nmi_q <= nmi_d;
  end
  assign nmi_o = nmi_q;

  // IRQ: level
  assign irq_o = |sub_act;

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_NMI_FLAG: reg_rdata_o[NMI_W-1:0]    = flag_nmi;
      A_NMI_EN:   reg_rdata_o[NMI_W-1:0]    = en_nmi;
      A_B0_FLAG:  reg_rdata_o[BUS_W-1:0]    = flag_b0;
      A_B0_EN:    reg_rdata_o[BUS_W-1:0]    = en_b0;
      A_B1_FLAG:  reg_rdata_o[BUS_W-1:0]    = flag_b1;
      A_B1_EN:    reg_rdata_o[BUS_W-1:0]    = en_b1;
      A_MS_FLAG:  reg_rdata_o[MISC_W-1:0]   = flag_ms;
      A_MS_EN:    reg_rdata_o[MISC_W-1:0]   = en_ms;
      A_EDGE:     reg_rdata_o[1:0]          = edge_q;
      A_STATUS:   reg_rdata_o[N_SUBGRP-1:0] = sub_act;
      default:    reg_rdata_o = '0;
    endcase
  end

  logic unused_act_nmi;
  assign unused_act_nmi = act_nmi;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n_s,
  input logic              nmi_o,
  input logic              irq_o,
  input logic              mute_evt_i,
  input logic              adc_done_i,
  input logic              reg_we_i,
  input logic [AW-1:0]     reg_addr_i,
  input logic [DW-1:0]     reg_wdata_i,
  input logic [NMI_W-1:0]  flag_nmi,
  input logic [NMI_W-1:0]  en_nmi,
  input logic [BUS_W-1:0]  flag_b0,
  input logic [BUS_W-1:0]  flag_b1,
  input logic [MISC_W-1:0] flag_ms
);
  // R2, R10: a mute strobe always leaves its flag set
  p_mute_sets_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    mute_evt_i |=> flag_nmi[1]);

  // R3: clearing write without a competing event empties the ADC flag
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_we_i && reg_addr_i == A_MS_FLAG && reg_wdata_i[MS_ADC] && !adc_done_i)
      |=> !flag_ms[MS_ADC]);

  // R3: event wins over a same-cycle clear
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (adc_done_i && reg_we_i && reg_addr_i == A_MS_FLAG) |=> flag_ms[MS_ADC]);

  // R4: no pending maskable flag means no IRQ
  p_irq_idle_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (flag_b0 == '0 && flag_b1 == '0 && flag_ms == '0) |-> !irq_o);

  // R5: an NMI pulse always leaves a pending NMI flag
  p_nmi_flag_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    nmi_o |-> (flag_nmi != '0));

  // R5: NMI stays quiet while the NMI enables have been zero
  p_nmi_masked_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (en_nmi == '0 && $past(en_nmi) == '0) |-> !nmi_o);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .nmi_o      (nmi_o),
  .irq_o      (irq_o),
  .mute_evt_i (mute_evt_i),
  .adc_done_i (adc_done_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .flag_nmi   (flag_nmi),
  .en_nmi     (en_nmi),
  .flag_b0    (flag_b0),
  .flag_b1    (flag_b1),
  .flag_ms    (flag_ms)
);

// File: tb/irq_ctrl_test.sv
`timescale 1ns/100ps
module irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext0_i, ext1_i, vsync_i, mute_evt_i, adc_done_i, tmr_wrap_i;
  logic [5:0] bus0_evt_i, bus1_evt_i;
  logic       reg_we_i;
  logic [3:0] reg_addr_i;
  logic [7:0] reg_wdata_i, reg_rdata_o;
  logic       nmi_o, irq_o;

  always #2.5 clk = ~clk;

  irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext0_i(ext0_i), .ext1_i(ext1_i),
    .vsync_i(vsync_i), .mute_evt_i(mute_evt_i), .adc_done_i(adc_done_i),
    .tmr_wrap_i(tmr_wrap_i), .bus0_evt_i(bus0_evt_i), .bus1_evt_i(bus1_evt_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .nmi_o(nmi_o), .irq_o(irq_o)
  );

  typedef struct {
    int         kind;   // 0 read data, 1 nmi_o, 2 irq_o, 3 nmi pulse count
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  event  do_sample;
  int    n_tests = 0, n_fail = 0;
  int    nmi_cnt = 0;
  bit    done = 0;

  always @(negedge clk) if (nmi_o === 1'b1) nmi_cnt++;

  // monitor: pop an expected item and compare it with what the design shows
  initial begin
    forever begin
      @(do_sample);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = reg_rdata_o;
          1: act = {7'b0, nmi_o};
          2: act = {7'b0, irq_o};
          default: act = nmi_cnt[7:0];
        endcase
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: kind %0d actual %02h expected %02h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  // driver: push the expectation, then trigger the monitor (ends on a negedge)
  task automatic chk(input int kind, input logic [3:0] addr, input logic [7:0] exp, input string req);
    item_t it;
    reg_addr_i = addr;
    #1;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    -> do_sample;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] addr, input logic [7:0] data);
    reg_we_i = 1'b1; reg_addr_i = addr; reg_wdata_i = data;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; ext0_i = 0; ext1_i = 0; vsync_i = 0; mute_evt_i = 0;
    adc_done_i = 0; tmr_wrap_i = 0; bus0_evt_i = '0; bus1_evt_i = '0;
    reg_we_i = 0; reg_addr_i = '0; reg_wdata_i = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    for (int a = 0; a < 10; a++) chk(0, 4'(a), 8'h00, "R1 reg after reset");
    chk(1, 0, 8'h00, "R1 nmi_o after reset");
    chk(2, 0, 8'h00, "R1 irq_o after reset");

    // R2, R10: ADC strobe with enable off
    adc_done_i = 1; @(negedge clk); adc_done_i = 0;
    chk(0, 4'h6, 8'h01, "R2 R10 adc flag set while disabled");
    chk(2, 0, 8'h00, "R4 irq low while disabled");

    // R4, R9: enable it
    wr(4'h7, 8'h01);
    chk(2, 0, 8'h01, "R4 irq high when enabled");
    chk(0, 4'h9, 8'h04, "R9 status subgroup 2");

    // R3: write 0 keeps, write 1 clears
    wr(4'h6, 8'h00);
    chk(0, 4'h6, 8'h01, "R3 write 0 keeps flag");
    wr(4'h6, 8'h01);
    chk(0, 4'h6, 8'h00, "R3 write 1 clears flag");
    chk(2, 0, 8'h00, "R4 irq drops after clear");

    // R3: event and clear in the same cycle
    adc_done_i = 1; reg_we_i = 1; reg_addr_i = 4'h6; reg_wdata_i = 8'h01;
    @(negedge clk);
    adc_done_i = 0; reg_we_i = 0; reg_wdata_i = '0;
    chk(0, 4'h6, 8'h01, "R3 event wins over clear");
    chk(2, 0, 8'h01, "R4 irq high with collided flag");
    wr(4'h7, 8'h00);
    chk(2, 0, 8'h00, "R4 irq drops when enable removed");
    wr(4'h6, 8'h0F);

    // R10, R8: timer wrap strobe lands at bit 3
    tmr_wrap_i = 1; @(negedge clk); tmr_wrap_i = 0;
    chk(0, 4'h6, 8'h08, "R10 R8 timer flag position");
    wr(4'h6, 8'h0F);

    // R8: bus channels stay separate
    bus0_evt_i = 6'h2A; @(negedge clk); bus0_evt_i = '0;
    chk(0, 4'h2, 8'h2A, "R8 bus0 pattern");
    bus1_evt_i = 6'h15; @(negedge clk); bus1_evt_i = '0;
    chk(0, 4'h4, 8'h15, "R8 bus1 pattern");
    chk(0, 4'h2, 8'h2A, "R8 bus0 untouched by bus1");
    chk(0, 4'h9, 8'h00, "R9 status zero with no enables");
    wr(4'h5, 8'h01);
    chk(0, 4'h9, 8'h02, "R9 status subgroup 1");
    chk(2, 0, 8'h01, "R4 irq from bus1");
    wr(4'h2, 8'h3F); wr(4'h4, 8'h3F); wr(4'h5, 8'h00);
    chk(2, 0, 8'h00, "R4 irq low after bus clears");

    // R7: vsync rising only
    vsync_i = 1; idle(5);
    chk(0, 4'h6, 8'h02, "R7 vsync rising sets flag");
    wr(4'h6, 8'h0F);
    vsync_i = 0; idle(5);
    chk(0, 4'h6, 8'h00, "R7 vsync falling ignored");

    // R6: ext1 rising by default, falling when selected
    ext1_i = 1; idle(5);
    chk(0, 4'h6, 8'h04, "R6 ext1 rising default");
    wr(4'h6, 8'h0F);
    ext1_i = 0; idle(5);
    chk(0, 4'h6, 8'h00, "R6 ext1 falling ignored in rising mode");
    wr(4'h8, 8'h02);
    chk(0, 4'h8, 8'h02, "R6 edge select readback");
    ext1_i = 1; idle(5);
    chk(0, 4'h6, 8'h00, "R6 ext1 rising ignored in falling mode");
    ext1_i = 0; idle(5);
    chk(0, 4'h6, 8'h04, "R6 ext1 falling sets flag");
    wr(4'h6, 8'h0F);

    // R5: mute NMI pulse
    wr(4'h1, 8'h02);
    mute_evt_i = 1; @(negedge clk); mute_evt_i = 0;
    chk(1, 0, 8'h01, "R5 nmi pulse high");
    chk(1, 0, 8'h00, "R5 nmi pulse one cycle");
    chk(0, 4'h0, 8'h02, "R10 mute flag");
    wr(4'h1, 8'h00); wr(4'h0, 8'h03);
    mute_evt_i = 1; @(negedge clk); mute_evt_i = 0;
    chk(1, 0, 8'h00, "R5 no pulse when disabled");
    chk(0, 4'h0, 8'h02, "R2 mute flag set while disabled");
    wr(4'h0, 8'h03);

    // R5, R6: ext0 rising through the synchronizer gives exactly one pulse
    wr(4'h1, 8'h01);
    base = nmi_cnt;
    ext0_i = 1; idle(6);
    chk(3, 0, 8'(base + 1), "R5 ext0 single nmi pulse");
    chk(0, 4'h0, 8'h01, "R6 ext0 flag");
    ext0_i = 0; idle(6);
    chk(3, 0, 8'(base + 1), "R6 ext0 falling ignored");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule